// File: doc/BRIEF.md
# Stereo Audio Frame Packetizer and Serializer

This block carries stereo audio samples across a one-bit serial link. On the send side it accepts a pair of 16-bit samples, one per channel, through a valid/ready handshake. It wraps each channel in its own 4-bit tag, which gives a 40-bit frame, and shifts that frame out one bit per cycle in which an external bit-enable strobe is high. The strobe sets the line rate, so the system holding the strobe keeps the link at or below 2 Mbit/s.

On the receive side it collects 40 serial bits, each qualified by a bit-valid input. It checks both tags and removes them, then places the two channels on a parallel output. A 4-bit select input decides which channels reach that output: the first channel, the second channel, or both. A channel that is not selected reads as zero. A frame whose tags are wrong is dropped and flagged with a one-cycle error pulse.

Top module: `stereo_frame_link`

## Requirements
- R1: While the active-low reset is applied, and in the first cycle after it, inReady is 1, serValid, outValid and frameError are 0, and outCh1 and outCh2 are zero.
- R2: A frame is 40 bits. From the most significant bit down it holds: the tag 4'b0001, the first channel (inLeft), the tag 4'b0010, and the second channel (inRight). Bit 39 is sent first.
- R3: While a frame is being sent, serValid is high in exactly the cycles where bitEn is high, and serOut then carries the next frame bit. serValid stays low whenever no frame is in progress. Cycles without bitEn do not advance the frame.
- R4: A sample pair is taken at a clock edge where inValid and inReady are both high. inReady is low from the next cycle until the 40th bit has been strobed out, and it is high again in the cycle after that.
- R5: Receive bits are shifted in, most significant first, on cycles where serInValid is high. Cycles without serInValid are ignored. In the cycle after the 40th bit, a frame with both tags correct gives a one-cycle outValid pulse, with the tags removed.
- R6: If either received tag differs from its expected code, frameError pulses for one cycle instead of outValid, and outCh1 and outCh2 keep their previous values.
- R7: Select code 4'b0001 places the first channel on outCh1 and drives outCh2 to zero.
- R8: Select code 4'b0010 places the second channel on outCh2 and drives outCh1 to zero.
- R9: Select code 4'b0011 places the first channel on outCh1 and the second channel on outCh2.
- R10: Any other select code drives both outCh1 and outCh2 to zero, and outValid still pulses.
- R11: The select code is sampled in the same cycle as the 40th received bit. Earlier values of the select code have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A sample pair is offered |
| inReady | output | 1 | The block can take a sample pair |
| inLeft | input | 16 | First-channel sample |
| inRight | input | 16 | Second-channel sample |
| bitEn | input | 1 | Bit-enable strobe for the serial output |
| serOut | output | 1 | Serial frame bit |
| serValid | output | 1 | serOut carries a bit this cycle |
| serIn | input | 1 | Serial receive bit |
| serInValid | input | 1 | serIn carries a bit this cycle |
| selCode | input | 4 | Output channel select code |
| outValid | output | 1 | One-cycle pulse: a good frame has been delivered |
| outCh1 | output | 16 | Received first channel, or zero if not selected |
| outCh2 | output | 16 | Received second channel, or zero if not selected |
| frameError | output | 1 | One-cycle pulse: a frame had a wrong tag |

## Verification
serOut and serValid follow bitEn in the same cycle, and the first frame bit is ready in the cycle after the handshake edge. inReady falls in the cycle after acceptance and rises in the cycle after the 40th strobe. A received result, either outValid or frameError, is registered and shows in the cycle after the edge that takes the 40th serial bit. The bench drives inputs just after the rising edge and compares against its queues at the falling edge. Each strobed bit and each result pulse pops exactly one queued expectation, so a result that comes a cycle early or late, or that is missing, shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_CH1  = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_CH2  = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_BOTH = 4'b0011;

  // strobes from the control to the datapath
  typedef struct packed {
    logic txLoad;   // load a new frame into the transmit shifter
    logic txShift;  // advance the transmit shifter by one bit
    logic rxShift;  // take one receive bit
    logic rxLast;   // the bit taken now completes a frame
  } sflStrobe_t;

endpackage

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int FRAME_W = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       bitEn,
  input  logic       serInValid,
  output logic       inReady,
  output logic       serValid,
  output sflStrobe_t stb
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic             txBusy;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;

  always_comb begin
    stb.txLoad  = inValid && !txBusy;
    stb.txShift = txBusy && bitEn;
    stb.rxShift = serInValid;
    stb.rxLast  = serInValid && (rxCnt == LAST_IDX);
    inReady     = !txBusy;
    serValid    = stb.txShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (stb.txLoad) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
    end else if (stb.txShift) begin
      if (txCnt == LAST_IDX) begin
        txBusy <= 1'b0;
        txCnt  <= '0;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt <= '0;
    end else if (stb.rxShift) begin
      rxCnt <= (rxCnt == LAST_IDX) ? '0 : rxCnt + 1'b1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady) else $error("ready stayed high after accept"); // R4

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(serValid)) else $error("ready rose without a final strobe"); // R4

  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (32'(rxCnt) < FRAME_W) && (32'(txCnt) < FRAME_W)) else $error("bit counter out of range"); // R5

endmodule

// File: rtl/sfl_datapath.sv
module sfl_datapath
  import sfl_pkg::*;
#(
  parameter int CH_W  = 16,
  parameter int HDR_W = 4,
  parameter logic [HDR_W-1:0] HDR1 = HDR_W'(1),
  parameter logic [HDR_W-1:0] HDR2 = HDR_W'(2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sflStrobe_t       stb,
  input  logic [CH_W-1:0]  inLeft,
  input  logic [CH_W-1:0]  inRight,
  output logic             serOut,
  input  logic             serIn,
  input  logic [SEL_W-1:0] selCode,
  output logic             outValid,
  output logic             frameError,
  output logic [CH_W-1:0]  outCh1,
  output logic [CH_W-1:0]  outCh2
);

  localparam int SLOT_W  = CH_W + HDR_W;
  localparam int FRAME_W = 2 * SLOT_W;

  logic [FRAME_W-1:0] txShreg;
  logic [FRAME_W-1:0] rxShreg;
  logic [FRAME_W-1:0] rxFull;
  logic [HDR_W-1:0]   rxHdr1, rxHdr2;
  logic [CH_W-1:0]    rxCh1, rxCh2;
  logic               hdrOk, passCh1, passCh2;

  // transmit shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShreg <= '0;
    end else if (stb.txLoad) begin
      txShreg <= {HDR1, inLeft, HDR2, inRight};
    end else if (stb.txShift) begin
      txShreg <= {txShreg[FRAME_W-2:0], 1'b0};
    end
  end

  assign serOut = txShreg[FRAME_W-1];

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShreg <= '0;
    end else if (stb.rxShift) begin
      rxShreg <= rxFull;
    end
  end

  always_comb begin
    rxFull  = {rxShreg[FRAME_W-2:0], serIn};
    rxHdr1  = rxFull[FRAME_W-1 -: HDR_W];
    rxCh1   = rxFull[FRAME_W-HDR_W-1 -: CH_W];
    rxHdr2  = rxFull[SLOT_W-1 -: HDR_W];
    rxCh2   = rxFull[CH_W-1:0];
    hdrOk   = (rxHdr1 == HDR1) && (rxHdr2 == HDR2);
    passCh1 = (selCode == SEL_CH1) || (selCode == SEL_BOTH);
    passCh2 = (selCode == SEL_CH2) || (selCode == SEL_BOTH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      frameError <= 1'b0;
      outCh1     <= '0;
      outCh2     <= '0;
    end else begin
      outValid   <= stb.rxLast && hdrOk;
      frameError <= stb.rxLast && !hdrOk;
      if (stb.rxLast && hdrOk) begin
        outCh1 <= passCh1 ? rxCh1 : '0;
        outCh2 <= passCh2 ? rxCh2 : '0;
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && frameError)) else $error("valid and error together"); // R6

  AST_ERR_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    frameError |-> ($stable(outCh1) && $stable(outCh2))) else $error("outputs moved on error"); // R6

  AST_SEL1_MUTES_CH2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(selCode) == SEL_CH1) |-> (outCh2 == '0)) else $error("ch2 not muted"); // R7

  AST_SEL2_MUTES_CH1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(selCode) == SEL_CH2) |-> (outCh1 == '0)) else $error("ch1 not muted"); // R8

  AST_BAD_SEL_MUTES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(selCode) != SEL_CH1 && $past(selCode) != SEL_CH2 &&
     $past(selCode) != SEL_BOTH) |-> (outCh1 == '0 && outCh2 == '0)) else $error("not muted"); // R10

endmodule

// File: rtl/stereo_frame_link.sv
module stereo_frame_link
  import sfl_pkg::*;
#(
  parameter int CH_W  = 16,
  parameter int HDR_W = 4,
  parameter logic [HDR_W-1:0] HDR1 = HDR_W'(1),
  parameter logic [HDR_W-1:0] HDR2 = HDR_W'(2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [CH_W-1:0]  inLeft,
  input  logic [CH_W-1:0]  inRight,
  input  logic             bitEn,
  output logic             serOut,
  output logic             serValid,
  input  logic             serIn,
  input  logic             serInValid,
  input  logic [SEL_W-1:0] selCode,
  output logic             outValid,
  output logic [CH_W-1:0]  outCh1,
  output logic [CH_W-1:0]  outCh2,
  output logic             frameError
);

  localparam int FRAME_W = 2 * (CH_W + HDR_W);

  sflStrobe_t stb;

  sfl_ctrl #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .bitEn      (bitEn),
    .serInValid (serInValid),
    .inReady    (inReady),
    .serValid   (serValid),
    .stb        (stb)
  );

  sfl_datapath #(.CH_W(CH_W), .HDR_W(HDR_W), .HDR1(HDR1), .HDR2(HDR2)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .inLeft     (inLeft),
    .inRight    (inRight),
    .serOut     (serOut),
    .serIn      (serIn),
    .selCode    (selCode),
    .outValid   (outValid),
    .frameError (frameError),
    .outCh1     (outCh1),
    .outCh2     (outCh2)
  );

  AST_FIRST_BIT_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (serOut == HDR1[HDR_W-1])) else $error("first bit not tag MSB"); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !(inValid && inReady)) |=> $stable(serOut)) else $error("bit moved without strobe"); // R3

endmodule

// File: tb/stereo_frame_link_tb.sv
module stereo_frame_link_tb_top;

  typedef struct {
    bit          isErr;
    logic [15:0] a;
    logic [15:0] b;
  } rxExp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inLeft = '0, inRight = '0;
  logic        bitEn = 1'b0;
  logic        serOut, serValid;
  logic        rxBit = 1'b0, rxVal = 1'b0, loopMode = 1'b1;
  logic        serInW, serInValidW;
  logic [3:0]  selCode = 4'b0011;
  logic        outValid, frameError;
  logic [15:0] outCh1, outCh2;

  int total = 0;
  int bad = 0;
  int enPeriod = 1;
  int cyc = 0;
  bit done = 0;
  bit txQ[$];
  rxExp_t rxQ[$];
  logic [15:0] lastA = '0, lastB = '0;

  always #10 clk = ~clk;

  assign serInW      = loopMode ? serOut : rxBit;
  assign serInValidW = loopMode ? serValid : rxVal;

  stereo_frame_link dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inLeft(inLeft), .inRight(inRight), .bitEn(bitEn), .serOut(serOut),
    .serValid(serValid), .serIn(serInW), .serInValid(serInValidW),
    .selCode(selCode), .outValid(outValid), .outCh1(outCh1), .outCh2(outCh2),
    .frameError(frameError)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic rxExp_t expFor(input logic [15:0] l, input logic [15:0] r,
                                    input logic [3:0] sel);
    rxExp_t e;
    e.isErr = 0;
    e.a = (sel == 4'b0001 || sel == 4'b0011) ? l : 16'h0;
    e.b = (sel == 4'b0010 || sel == 4'b0011) ? r : 16'h0;
    return e;
  endfunction

  // strobe generator
  always @(posedge clk) begin
    cyc++;
    #1 bitEn = ((cyc % enPeriod) == 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(inReady == (txQ.size() == 0), "R4", "inReady", 32'(inReady), 32'(txQ.size() == 0));
      if (txQ.size() > 0 && bitEn) begin
        bit e;
        e = txQ.pop_front();
        chk(serValid == 1'b1, "R3", "serValid on strobe", 32'(serValid), 1);
        chk(serOut == e, "R2", "serial bit", 32'(serOut), 32'(e));
      end else if (serValid) begin
        chk(0, "R3", "serValid without strobe or frame", 32'(serValid), 0);
      end
      if (outValid || frameError) begin
        if (rxQ.size() == 0) begin
          chk(0, "R5", "unexpected result pulse", {outValid, frameError}, 0);
        end else begin
          rxExp_t e;
          e = rxQ.pop_front();
          if (e.isErr) begin
            chk(frameError && !outValid, "R6", "error pulse", {outValid, frameError}, 1);
            chk(outCh1 == lastA && outCh2 == lastB, "R6", "outputs held",
                {outCh1, outCh2}, {lastA, lastB});
          end else begin
            chk(outValid && !frameError, "R5", "valid pulse", {outValid, frameError}, 2);
            chk(outCh1 == e.a && outCh2 == e.b, "R7 R8 R9 R10", "channel data",
                {outCh1, outCh2}, {e.a, e.b});
            lastA = e.a;
            lastB = e.b;
          end
        end
      end
    end
  end

  // driver: offer one sample pair through the handshake (loop mode)
  task automatic sendPair(input logic [15:0] l, input logic [15:0] r, input logic [3:0] sel);
    logic [39:0] fr;
    do begin
      @(posedge clk); #2;
    end while (!inReady);
    selCode = sel;
    inValid = 1'b1;
    inLeft  = l;
    inRight = r;
    rxQ.push_back(expFor(l, r, sel));
    @(posedge clk); #2;
    inValid = 1'b0;
    fr = {4'b0001, l, 4'b0010, r};
    for (int i = 39; i >= 0; i--) txQ.push_back(fr[i]);
  endtask

  // direct drive of the receive input; selection changes before the last bit
  task automatic injectFrame(input logic [39:0] fr, input logic [3:0] selStart,
                             input logic [3:0] selLast, input int gap, input bit isErr);
    rxExp_t e;
    if (isErr) begin
      e.isErr = 1; e.a = '0; e.b = '0;
    end else begin
      e = expFor(fr[35:20], fr[15:0], selLast);
    end
    rxQ.push_back(e);
    selCode = selStart;
    for (int i = 39; i >= 0; i--) begin
      @(posedge clk); #2;
      if (i == 0) selCode = selLast;
      rxBit = fr[i];
      rxVal = 1'b1;
      @(posedge clk); #2;
      rxVal = 1'b0;
      rxBit = ~rxBit;  // noise while not valid
      for (int g = 0; g < gap; g++) @(posedge clk);
    end
  endtask

  task automatic waitIdle();
    while (txQ.size() != 0 || rxQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state while reset is applied
    chk(inReady == 1'b1 && serValid == 1'b0, "R1", "ready/valid in reset", {inReady, serValid}, 2);
    chk(outValid == 1'b0 && frameError == 1'b0, "R1", "result flags in reset", {outValid, frameError}, 0);
    chk(outCh1 == '0 && outCh2 == '0, "R1", "outputs in reset", {outCh1, outCh2}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1 && serValid == 1'b0, "R1", "ready after reset", {inReady, serValid}, 2);

    // loop mode with several strobe rates and selections (R2 R3 R4 R5 R7 R8 R9)
    loopMode = 1'b1;
    enPeriod = 1; sendPair(16'hA5C3, 16'h1E69, 4'b0011); waitIdle();
    enPeriod = 3; sendPair(16'h8001, 16'h7FFE, 4'b0001); waitIdle();
    enPeriod = 2; sendPair(16'h1234, 16'hFEDC, 4'b0010); waitIdle();
    // R10: select codes outside the three listed mute both
    enPeriod = 1; sendPair(16'hCAFE, 16'hBEEF, 4'b0000); waitIdle();
    sendPair(16'h0F0F, 16'hF0F0, 4'b0111); waitIdle();
    // back-to-back pairs, R4
    sendPair(16'hFFFF, 16'h0000, 4'b0011);
    sendPair(16'h0000, 16'hFFFF, 4'b0011);
    waitIdle();

    // direct receive drive with gaps; R11 select sampled at last bit
    loopMode = 1'b0;
    injectFrame({4'b0001, 16'h3C3C, 4'b0010, 16'h5A5A}, 4'b0001, 4'b0011, 2, 0); waitIdle();
    injectFrame({4'b0001, 16'h4444, 4'b0010, 16'h9999}, 4'b0011, 4'b0010, 0, 0); waitIdle();
    // R6: bad first tag, then bad second tag
    injectFrame({4'b0101, 16'h1111, 4'b0010, 16'h2222}, 4'b0011, 4'b0011, 1, 1); waitIdle();
    injectFrame({4'b0001, 16'h3333, 4'b1010, 16'h4444}, 4'b0011, 4'b0011, 0, 1); waitIdle();
    injectFrame({4'b0001, 16'hFFFF, 4'b0010, 16'hFFFF}, 4'b0011, 4'b0011, 0, 0); waitIdle();

    chk(txQ.size() == 0, "R3", "all sent bits observed", 32'(txQ.size()), 0);
    chk(rxQ.size() == 0, "R5", "all results observed", 32'(rxQ.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule